// File: doc/BRIEF.md
# Servo Pulse Generator with Source Select

This block drives one hobby-servo control line. Every frame it emits a single high pulse whose length encodes a signed 10-bit position command. The pulse length is a linear function of the command. The most negative command gives the shortest pulse and the most positive command gives the longest. With the default parameters the clock is 50 MHz, one timing tick is 1 µs, a frame lasts 20 ms, and the pulse spans 0.8 ms to 2.2 ms. A command of zero gives 1.5 ms.

Two command sources share the one servo path. One source is the value decoded from a manual radio channel. The other is a value written by software. A select input picks the source. The selected command, the select input and the enable input are all captured at the first tick of each frame. Inputs that change later in a frame therefore cannot cut short or distort the pulse in flight.

Top module: `servo_pulse_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first frame starts, `servo_o` is low.
- R2: The first frame after reset uses the centred command (value 0). At the test timing this gives a width of MIN_TICKS + 700 = 1500 ticks, whatever the command, select and enable-independent source inputs are.
- R3: A frame starts every FRAME_TICKS ticks exactly. The first frame starts on the first tick after reset.
- R4: The width in ticks depends on the command, read as two's complement. A value of 10'h200 (-512) gives exactly MIN_TICKS. A value of 10'h1FF (+511) gives exactly MAX_TICKS. A value of 0 gives 1500 when MIN_TICKS=800 and MAX_TICKS=2200. Every other command gives a width within one tick of MIN_TICKS + (cmd+512)*(MAX_TICKS-MIN_TICKS)/1023.
- R5: `src_sel` = 0 takes the command from `radio_cmd`. `src_sel` = 1 takes it from `sw_cmd`.
- R6: Command, select and enable are sampled only at frame start. Changes to them during a frame leave that frame's pulse unchanged.
- R7: If `enable` is low when a frame starts, the line stays low for the whole of that frame.
- R8: When the line is enabled, it rises on the frame-start tick and forms one contiguous high interval. That interval ends before the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Line enable, captured at each frame start |
| src_sel | input | 1 | Source select: 0 = radio, 1 = software |
| radio_cmd | input | 10 | Two's-complement command decoded from the radio channel |
| sw_cmd | input | 10 | Two's-complement command written by software |
| servo_o | output | 1 | Servo control line |

## Verification
The bound checker watches several properties on every cycle:
- the line stays low until the first frame is armed;
- frame starts are spaced exactly FRAME_TICKS ticks apart;
- the line rises only right after a frame start, and only when the enable was latched high;
- the latched width changes only at a frame start and stays within MIN_TICKS..MAX_TICKS.

Some behaviours can only be shown by the bench's scenarios: the exact width reached for each command, which source the select picks, the centred first frame, and the fact that mid-frame changes to the inputs are ignored.

// File: rtl/servo_pkg.sv
package servo_pkg;

  localparam int CMD_W     = 10;
  localparam int CMD_STEPS = (1 << CMD_W) - 1;
  localparam int FRAC_W    = 16;

  // Fixed-point gain, rounded up so that the top command lands exactly on MAX.
  function automatic longint unsigned gain_for(input longint unsigned span);
    longint unsigned num;
    num = span * (64'd1 << FRAC_W);
    return (num + longint'(CMD_STEPS) - 1) / longint'(CMD_STEPS);
  endfunction

  // Bias the two's-complement command into 0 .. CMD_STEPS.
  function automatic longint unsigned cmd_offset(input logic [CMD_W-1:0] cmd);
    return 64'({~cmd[CMD_W-1], cmd[CMD_W-2:0]});
  endfunction

  // Pulse width in ticks, clamped at the upper limit.
  function automatic longint unsigned cmd_to_ticks(
    input logic [CMD_W-1:0] cmd,
    input longint unsigned  min_t,
    input longint unsigned  max_t,
    input longint unsigned  gain
  );
    longint unsigned w;
    w = min_t + ((cmd_offset(cmd) * gain) >> FRAC_W);
    if (w > max_t) w = max_t;
    return w;
  endfunction

endpackage

// File: rtl/servo_tick_gen.sv
module servo_tick_gen #(
  parameter int CLKS_PER_TICK = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick_o = (div_q == LAST);

endmodule

// File: rtl/servo_frame_timer.sv
module servo_frame_timer #(
  parameter int FRAME_TICKS = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic frame_start_o
);

  localparam int FW = $clog2(FRAME_TICKS);
  localparam logic [FW-1:0] LAST = FW'(FRAME_TICKS - 1);

  logic [FW-1:0] phase_q;

  // Reset to the last phase so that the first tick opens a frame.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= LAST;
    end else if (tick_i) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign frame_start_o = tick_i && (phase_q == LAST);

endmodule

// File: rtl/servo_cmd_latch.sv
module servo_cmd_latch
  import servo_pkg::*;
#(
  parameter int MIN_TICKS = 800,
  parameter int MAX_TICKS = 2200,
  parameter int WW        = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic             sel_i,
  input  logic             en_i,
  input  logic [CMD_W-1:0] radio_cmd_i,
  input  logic [CMD_W-1:0] sw_cmd_i,
  output logic [WW-1:0]    load_width_o,
  output logic             load_en_o,
  output logic [WW-1:0]    width_q_o,
  output logic             en_q_o,
  output logic             armed_o
);

  localparam longint unsigned GAIN = gain_for(64'(MAX_TICKS - MIN_TICKS));

  logic [CMD_W-1:0] cmd_sel;
  logic [CMD_W-1:0] cmd_use;

  // Source multiplexer; the centred command stands in until the first frame.
  assign cmd_sel      = sel_i ? sw_cmd_i : radio_cmd_i;
  assign cmd_use      = armed_o ? cmd_sel : '0;
  assign load_width_o = WW'(cmd_to_ticks(cmd_use, 64'(MIN_TICKS), 64'(MAX_TICKS), GAIN));
  assign load_en_o    = en_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q_o <= '0;
      en_q_o    <= 1'b0;
      armed_o   <= 1'b0;
    end else if (frame_start_i) begin
      width_q_o <= load_width_o;
      en_q_o    <= load_en_o;
      armed_o   <= 1'b1;
    end
  end

endmodule

// File: rtl/servo_pulse_shaper.sv
module servo_pulse_shaper #(
  parameter int WW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          frame_start_i,
  input  logic [WW-1:0] load_width_i,
  input  logic          load_en_i,
  output logic          pulse_o
);

  logic [WW-1:0] hi_left_q;

  // The line is registered, so it changes only on clock edges and never glitches.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_left_q <= '0;
      pulse_o   <= 1'b0;
    end else if (frame_start_i) begin
      hi_left_q <= load_en_i ? load_width_i : '0;
      pulse_o   <= load_en_i && (load_width_i != '0);
    end else if (tick_i && (hi_left_q != '0)) begin
      hi_left_q <= hi_left_q - 1'b1;
      if (hi_left_q == WW'(1)) pulse_o <= 1'b0;
    end
  end

endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen
  import servo_pkg::*;
#(
  parameter int CLKS_PER_TICK = 50,
  parameter int FRAME_TICKS   = 20000,
  parameter int MIN_TICKS     = 800,
  parameter int MAX_TICKS     = 2200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             src_sel,
  input  logic [CMD_W-1:0] radio_cmd,
  input  logic [CMD_W-1:0] sw_cmd,
  output logic             servo_o
);

  localparam int WW = $clog2(MAX_TICKS + 1);

  // Named internal events, observed by the bound checker.
  logic          tick;
  logic          frame_start;
  logic [WW-1:0] load_width;
  logic          load_en;
  logic [WW-1:0] width_lat;
  logic          en_lat;
  logic          armed;

  servo_tick_gen #(
    .CLKS_PER_TICK(CLKS_PER_TICK)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  servo_frame_timer #(
    .FRAME_TICKS(FRAME_TICKS)
  ) u_frame (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick),
    .frame_start_o (frame_start)
  );

  servo_cmd_latch #(
    .MIN_TICKS(MIN_TICKS),
    .MAX_TICKS(MAX_TICKS),
    .WW       (WW)
  ) u_latch (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start),
    .sel_i         (src_sel),
    .en_i          (enable),
    .radio_cmd_i   (radio_cmd),
    .sw_cmd_i      (sw_cmd),
    .load_width_o  (load_width),
    .load_en_o     (load_en),
    .width_q_o     (width_lat),
    .en_q_o        (en_lat),
    .armed_o       (armed)
  );

  servo_pulse_shaper #(
    .WW(WW)
  ) u_shaper (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick),
    .frame_start_i (frame_start),
    .load_width_i  (load_width),
    .load_en_i     (load_en),
    .pulse_o       (servo_o)
  );

endmodule

// File: rtl/servo_pulse_gen_chk.sv
module servo_pulse_gen_chk #(
  parameter int FRAME_TICKS = 20000,
  parameter int MIN_TICKS   = 800,
  parameter int MAX_TICKS   = 2200,
  parameter int WW          = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          frame_start,
  input logic          servo,
  input logic          armed,
  input logic          en_lat,
  input logic [WW-1:0] width_lat
);

  int   ticks_since;
  logic seen_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ticks_since <= 0;
      seen_start  <= 1'b0;
    end else if (frame_start) begin
      ticks_since <= 0;
      seen_start  <= 1'b1;
    end else if (tick) begin
      ticks_since <= ticks_since + 1;
    end
  end

  assert_low_until_armed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !servo);

  assert_frame_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && seen_start) |-> (ticks_since == FRAME_TICKS - 1));

  assert_width_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((width_lat >= WW'(MIN_TICKS)) && (width_lat <= WW'(MAX_TICKS))));

  assert_width_held_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(width_lat));

  assert_rise_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(servo) |-> en_lat);

  assert_rise_at_frame_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(servo) |-> $past(frame_start));

endmodule

bind servo_pulse_gen servo_pulse_gen_chk #(
  .FRAME_TICKS(FRAME_TICKS),
  .MIN_TICKS  (MIN_TICKS),
  .MAX_TICKS  (MAX_TICKS),
  .WW         (WW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .frame_start (frame_start),
  .servo       (servo_o),
  .armed       (armed),
  .en_lat      (en_lat),
  .width_lat   (width_lat)
);

// File: tb/servo_pulse_gen_tb.sv
module servo_pulse_gen_tb;

  localparam int PRE  = 1;
  localparam int F    = 2500;
  localparam int MINT = 800;
  localparam int MAXT = 2200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic       src_sel = 1'b0;
  logic [9:0] radio_cmd = '0;
  logic [9:0] sw_cmd = '0;
  logic       servo_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  servo_pulse_gen #(
    .CLKS_PER_TICK(PRE),
    .FRAME_TICKS  (F),
    .MIN_TICKS    (MINT),
    .MAX_TICKS    (MAXT)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .src_sel   (src_sel),
    .radio_cmd (radio_cmd),
    .sw_cmd    (sw_cmd),
    .servo_o   (servo_o)
  );

  // Ideal linear width, in real arithmetic.
  function automatic real ideal_width(input logic [9:0] cmd);
    int v;
    v = $signed(cmd);
    return MINT + real'(v + 512) * real'(MAXT - MINT) / 1023.0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Call on the falling edge just before a frame-start edge.
  // exact >= 0: width must match exactly; exact < 0: within one tick of the ideal value.
  task automatic run_frame(input bit sel, input logic [9:0] rc, input logic [9:0] sc,
                           input bit en, input bit disturb, input int exact,
                           input real ideal, input string req);
    int  hc;
    int  gaps;
    bit  first_hi;
    bit  last_hi;
    real diff;
    src_sel = sel; radio_cmd = rc; sw_cmd = sc; enable = en;
    hc = 0; gaps = 0; first_hi = 0; last_hi = 0;
    for (int i = 0; i < F; i++) begin
      @(negedge clk);
      if (disturb && i == 5) begin
        src_sel = ~sel; radio_cmd = 10'($urandom); sw_cmd = 10'($urandom); enable = ~en;
      end
      if (i == 0) first_hi = servo_o;
      if (i == F - 1) last_hi = servo_o;
      if (servo_o) begin
        hc++;
        if (i != hc - 1) gaps++;
      end
    end
    // R8: one contiguous pulse that starts at the frame start and ends inside the frame.
    check(gaps == 0 && !last_hi && (first_hi == (hc != 0)), "R8 shape", gaps, 0);
    if (!en) begin
      check(hc == 0, {req, " R7 disabled frame"}, hc, 0);
    end else if (exact >= 0) begin
      check(hc == exact, req, hc, exact);
    end else begin
      diff = real'(hc) - ideal;
      if (diff < 0.0) diff = -diff;
      check(diff < 1.0, req, hc, int'(ideal));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    checks++;
    errors++;
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: line low during reset.
    repeat (5) begin
      @(negedge clk);
      check(servo_o == 1'b0, "R1 reset low", servo_o, 0);
    end
    rst_n = 1'b1;
    // R2: the first frame is centred even though extreme commands are presented.
    run_frame(1'b1, 10'h200, 10'h1FF, 1'b1, 1'b0, 1500, 0.0, "R2 first frame centred");
    // R4: endpoints and zero.
    run_frame(1'b0, 10'h200, 10'h000, 1'b1, 1'b0, MINT, 0.0, "R4 min command");
    run_frame(1'b0, 10'h1FF, 10'h000, 1'b1, 1'b0, MAXT, 0.0, "R4 max command");
    run_frame(1'b1, 10'h1FF, 10'h000, 1'b1, 1'b0, 1500, 0.0, "R4 zero command");
    // R5: the select picks the source.
    run_frame(1'b1, 10'h200, 10'h1FF, 1'b1, 1'b0, MAXT, 0.0, "R5 software source");
    run_frame(1'b0, 10'h200, 10'h1FF, 1'b1, 1'b0, MINT, 0.0, "R5 radio source");
    // R6: mid-frame changes are ignored.
    run_frame(1'b0, 10'd100, 10'h3F0, 1'b1, 1'b1, -1, ideal_width(10'd100), "R6 mid-frame change");
    run_frame(1'b1, 10'h1FF, 10'h200, 1'b1, 1'b1, MINT, 0.0, "R6 mid-frame change exact");
    // R7: enable low at frame start gives a low frame, even if enable rises mid-frame.
    run_frame(1'b0, 10'h1FF, 10'h1FF, 1'b0, 1'b0, 0, 0.0, "R7 enable low");
    run_frame(1'b1, 10'h1FF, 10'h1FF, 1'b0, 1'b1, 0, 0.0, "R7 enable low disturbed");
    // R3: full-width frame next to a re-enabled frame keeps the period.
    run_frame(1'b0, 10'h1FF, 10'h000, 1'b1, 1'b0, MAXT, 0.0, "R3 period after disabled frame");
    // Random commands and sources (R4, R5).
    for (int k = 0; k < 14; k++) begin
      logic       s;
      logic [9:0] rc;
      logic [9:0] sc;
      s  = 1'($urandom);
      rc = 10'($urandom);
      sc = 10'($urandom);
      run_frame(s, rc, sc, 1'b1, 1'($urandom), -1, ideal_width(s ? sc : rc), "R4 R5 random");
    end
    finish_run();
  end

endmodule